// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the eight-bit status register of an asynchronous serial port. It holds the flags that report the state of the transmit and receive paths. The transmitter and receiver update the flags through single-cycle event strobes. The CPU reads the whole byte through a read port and changes it through a write port.

Software can only clear flags, never set them. It can clear a flag only after it has seen that flag as 1 in an earlier read. The transmit side is an enumerated machine with three states:
- `TX_IDLE`: buffer empty, transmission finished.
- `TX_HELD`: data is waiting in the buffer.
- `TX_DRAIN`: the buffer is empty again but the last frame is still shifting out.

Its transitions are:
- *load*: `TX_IDLE` or `TX_DRAIN` to `TX_HELD`, on a data write or an armed software clear.
- *hand-off*: `TX_HELD` to `TX_DRAIN`, on a transfer or disable strobe.
- *finish*: `TX_DRAIN` to `TX_IDLE`, on frame end.

Each receive-side flag is a small machine of its own with three states:
- `FL_CLEAR`: flag is 0.
- `FL_SET`: flag is 1 but not armed.
- `FL_ARMED`: flag is 1 and has been seen by a read.

Its transitions are:
- *raise*: to `FL_SET`, on the event strobe.
- *observe*: `FL_SET` to `FL_ARMED`, on a read.
- *acknowledge*: `FL_ARMED` to `FL_CLEAR`, on a write of 0 to that bit.

Entering a low-power mode reloads the reset value into every flag.

Top module: `uart_status_reg`

## Requirements
- R1: After reset the register reads 0x84. The bit positions are: 7 tx-empty, 6 rx-full, 5 overrun, 4 framing error, 3 parity error, 2 tx-end, 1 received multiprocessor bit, 0 transmit multiprocessor bit.
- R2: A cycle with `lp_enter` high makes the register read 0x84 on the next cycle. This overrides every other input in that cycle.
- R3: A CPU write with a 1 in bit 7, 6, 5, 4 or 3 never sets that flag. A write leaves bits 2 and 1 unchanged whatever their data.
- R4: Arming and clearing by software works as follows:
  - A read strobe while one of bits 7..3 is 1 arms that bit.
  - A later CPU write with 0 in that bit clears the flag only if the bit is armed. A write of 0 to an unarmed bit leaves it unchanged and leaves it unarmed.
  - Any cycle in which the flag ends at 0 disarms it.
  - A read together with a write of 0 that does not clear the flag leaves the bit armed.
  - The write consumes the arming that existed before the cycle.
- R5: A strobe on `tdr_wr` clears tx-empty (bit 7) and tx-end (bit 2) on the next cycle, unless a set event for tx-empty arrives in the same cycle.
- R6: A strobe on `xfer` or `tx_dis` sets tx-empty. A set event wins over any clear of tx-empty in the same cycle.
- R7: Tx-end becomes 1 when `frame_end` strobes while tx-empty already reads 1, unless tx-empty is cleared in that cycle. Tx-end becomes 0 whenever tx-empty is cleared, and it is never 1 while tx-empty is 0.
- R8: The strobes `rx_done`, `ovr_err`, `frm_err` and `par_err` set bits 6, 5, 4 and 3 respectively. Such a set wins over a software clear of the same bit in the same cycle.
- R9: On `rx_done`, bit 1 captures `rx_mpb`. Otherwise bit 1 holds its value.
- R10: Every CPU write loads bit 0 from `wdata[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_enter | input | 1 | Low-power entry strobe; reloads the reset value |
| rd_stb | input | 1 | CPU read of the register this cycle |
| wr_stb | input | 1 | CPU write of the register this cycle |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Current register value |
| tdr_wr | input | 1 | CPU write to the transmit data register |
| xfer | input | 1 | Transmit buffer moved into the shifter |
| tx_dis | input | 1 | Transmit enable was turned off |
| frame_end | input | 1 | Transmitter finished shifting a frame |
| rx_done | input | 1 | Receiver completed a frame |
| rx_mpb | input | 1 | Multiprocessor bit of the received frame |
| ovr_err | input | 1 | Receiver overrun detected |
| frm_err | input | 1 | Receiver framing error detected |
| par_err | input | 1 | Receiver parity error detected |

## Verification
Each internal state drives a visible bit, except the arming, so a wrong flag value shows on `rdata` one cycle after the event that caused it. Wrong arming is invisible until the next software write of 0. Such a write then clears a flag that should have stayed, or keeps one that should have gone, and the error appears one cycle later. The random sequences therefore interleave reads, writes and hardware events densely. Each cycle is compared with a reference model, so arming errors surface within a few cycles.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int STAT_W  = 8;
    localparam int B_TXE   = 7;
    localparam int B_RXF   = 6;
    localparam int B_OVR   = 5;
    localparam int B_FRM   = 4;
    localparam int B_PAR   = 3;
    localparam int B_TEND  = 2;
    localparam int B_MPR   = 1;
    localparam int B_MPT   = 0;
    localparam int N_RXFL  = B_RXF - B_PAR + 1;
    localparam logic [STAT_W-1:0] STAT_RST = 8'h84;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_SET   = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HELD  = 2'd1,
        TX_DRAIN = 2'd2
    } tx_state_e;
endpackage

// File: rtl/uart_stat_flag.sv
module uart_stat_flag
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;
    logic        wr_zero;

    assign wr_zero = wr_i && !wbit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FL_CLEAR;
        else if (lp_i)
            state_q <= FL_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (set_i) begin
            if (rd_i && state_q != FL_CLEAR)
                state_d = FL_ARMED;
            else if (wr_zero)
                state_d = FL_SET;
            else if (state_q == FL_CLEAR)
                state_d = FL_SET;
        end else begin
            unique case (state_q)
                FL_CLEAR: state_d = FL_CLEAR;
                FL_SET:   state_d = rd_i ? FL_ARMED : FL_SET;
                FL_ARMED: state_d = wr_zero ? FL_CLEAR : FL_ARMED;
                default:  state_d = FL_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag_o = (state_q != FL_CLEAR);
    end

    // R3
    wr_one_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_CLEAR && wr_i && wbit_i && !set_i) |=> !flag_o);

    // R4
    unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_SET && !lp_i) |=> flag_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !lp_i) |=> flag_o);
endmodule

// File: rtl/uart_stat_txfsm.sv
module uart_stat_txfsm
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic tdr_wr_i,
    input  logic xfer_i,
    input  logic dis_i,
    input  logic fend_i,
    output logic txe_o,
    output logic tend_o
);
    tx_state_e state_q, state_d;
    logic      arm_q, arm_d;
    logic      set_ev, clr_ev, txe_cur, wr_zero;

    assign wr_zero = wr_i && !wbit_i;
    assign set_ev  = xfer_i || dis_i;
    assign clr_ev  = tdr_wr_i || (wr_zero && arm_q);
    assign txe_cur = (state_q != TX_HELD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            arm_q   <= 1'b0;
        end else if (lp_i) begin
            state_q <= TX_IDLE;
            arm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            arm_q   <= arm_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (!set_ev && clr_ev) state_d = TX_HELD;
            end
            TX_HELD: begin
                if (set_ev) state_d = TX_DRAIN;
            end
            TX_DRAIN: begin
                if (!set_ev && clr_ev) state_d = TX_HELD;
                else if (fend_i)       state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        if (state_d == TX_HELD)  arm_d = 1'b0;
        else if (rd_i && txe_cur) arm_d = 1'b1;
        else if (wr_zero)        arm_d = 1'b0;
        else                     arm_d = arm_q;
    end

    always_comb begin
        txe_o  = (state_q != TX_HELD);
        tend_o = (state_q == TX_IDLE);
    end

    // R7
    tend_needs_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tend_o |-> txe_o);

    // R6
    txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && !lp_i) |=> txe_o);

    // R5
    tdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_wr_i && !set_ev && !lp_i) |=> (!txe_o && !tend_o));
endmodule

// File: rtl/uart_status_reg.sv
module uart_status_reg
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_enter,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] rdata,
    input  logic              tdr_wr,
    input  logic              xfer,
    input  logic              tx_dis,
    input  logic              frame_end,
    input  logic              rx_done,
    input  logic              rx_mpb,
    input  logic              ovr_err,
    input  logic              frm_err,
    input  logic              par_err
);
    logic              txe, tend, mpr_q, mpt_q;
    logic [N_RXFL-1:0] rx_set, rx_flag;
    logic              unused_wbits;

    assign unused_wbits = ^wdata[B_TEND:B_MPR];
    assign rx_set = {rx_done, ovr_err, frm_err, par_err};

    uart_stat_txfsm u_txfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_i     (lp_enter),
        .rd_i     (rd_stb),
        .wr_i     (wr_stb),
        .wbit_i   (wdata[B_TXE]),
        .tdr_wr_i (tdr_wr),
        .xfer_i   (xfer),
        .dis_i    (tx_dis),
        .fend_i   (frame_end),
        .txe_o    (txe),
        .tend_o   (tend)
    );

    for (genvar gi = 0; gi < N_RXFL; gi++) begin : g_rxfl
        uart_stat_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .lp_i   (lp_enter),
            .set_i  (rx_set[gi]),
            .rd_i   (rd_stb),
            .wr_i   (wr_stb),
            .wbit_i (wdata[B_PAR+gi]),
            .flag_o (rx_flag[gi])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mpr_q <= STAT_RST[B_MPR];
            mpt_q <= STAT_RST[B_MPT];
        end else if (lp_enter) begin
            mpr_q <= STAT_RST[B_MPR];
            mpt_q <= STAT_RST[B_MPT];
        end else begin
            if (rx_done) mpr_q <= rx_mpb;
            if (wr_stb)  mpt_q <= wdata[B_MPT];
        end
    end

    always_comb begin
        rdata                = '0;
        rdata[B_TXE]         = txe;
        rdata[B_RXF:B_PAR]   = rx_flag;
        rdata[B_TEND]        = tend;
        rdata[B_MPR]         = mpr_q;
        rdata[B_MPT]         = mpt_q;
    end

    // R2
    lp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lp_enter |=> (rdata == STAT_RST));

    // R9
    mpb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !lp_enter) |=> (rdata[B_MPR] == $past(rx_mpb)));

    // R10
    mpt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !lp_enter) |=> (rdata[B_MPT] == $past(wdata[B_MPT])));
endmodule

// File: tb/uart_status_reg_bench.sv
module uart_status_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_enter = 0, rd_stb = 0, wr_stb = 0, tdr_wr = 0, xfer = 0, tx_dis = 0;
    logic frame_end = 0, rx_done = 0, rx_mpb = 0, ovr_err = 0, frm_err = 0, par_err = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic       m_txe, m_tend, m_tarm, m_mpr, m_mpt;
    logic [3:0] m_fl, m_arm;

    uart_status_reg u_uart_status_reg (
        .clk(clk), .rst_n(rst_n), .lp_enter(lp_enter), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .tdr_wr(tdr_wr),
        .xfer(xfer), .tx_dis(tx_dis), .frame_end(frame_end), .rx_done(rx_done),
        .rx_mpb(rx_mpb), .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_byte();
        return {m_txe, m_fl[3], m_fl[2], m_fl[1], m_fl[0], m_tend, m_mpr, m_mpt};
    endfunction

    function automatic string tag_of(input logic [7:0] diff, input string deflt);
        if (diff[7])        return "R6";
        if (diff[2])        return "R7";
        if (|diff[6:3])     return "R8";
        if (diff[1])        return "R9";
        if (diff[0])        return "R10";
        return deflt;
    endfunction

    task automatic model_reset();
        m_txe = 1; m_tend = 1; m_tarm = 0; m_mpr = 0; m_mpt = 0;
        m_fl = '0; m_arm = '0;
    endtask

    task automatic model_step();
        logic set_t, clr_t, txe_q, ntxe, ntend;
        logic [3:0] rs;
        if (lp_enter) begin
            model_reset();
            return;
        end
        set_t = xfer | tx_dis;
        clr_t = tdr_wr | (wr_stb & ~wdata[7] & m_tarm);
        txe_q = m_txe;
        ntxe  = set_t ? 1'b1 : (clr_t ? 1'b0 : txe_q);
        if (!set_t && clr_t) ntend = 1'b0;
        else                 ntend = m_tend | (frame_end & txe_q);
        if (!ntxe)                          m_tarm = 0;
        else if (rd_stb && txe_q)           m_tarm = 1;
        else if (wr_stb && !wdata[7])       m_tarm = 0;
        m_txe = ntxe; m_tend = ntend;
        rs = {rx_done, ovr_err, frm_err, par_err};
        for (int i = 0; i < 4; i++) begin
            logic fq, nf;
            fq = m_fl[i];
            if (rs[i])                                      nf = 1;
            else if (m_arm[i] && wr_stb && !wdata[3+i])     nf = 0;
            else                                            nf = fq;
            if (!nf)                                m_arm[i] = 0;
            else if (rd_stb && fq)                  m_arm[i] = 1;
            else if (wr_stb && !wdata[3+i])         m_arm[i] = 0;
            m_fl[i] = nf;
        end
        if (rx_done) m_mpr = rx_mpb;
        if (wr_stb)  m_mpt = wdata[0];
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        lp_enter = 0; rd_stb = 0; wr_stb = 0; tdr_wr = 0; xfer = 0; tx_dis = 0;
        frame_end = 0; rx_done = 0; rx_mpb = 0; ovr_err = 0; frm_err = 0; par_err = 0;
    endtask

    // inputs already set at a falling edge; advance one cycle and compare
    task automatic step(input string tag);
        logic [7:0] e;
        model_step();
        @(negedge clk);
        e = exp_byte();
        check(rdata, e, tag_of(rdata ^ e, tag));
        clear_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset value and layout
        check(rdata, 8'h84, "R1");

        // R4: write 0 without prior read does nothing to tx-empty
        wr_stb = 1; wdata = 8'h00; step("R4");
        check(rdata, 8'h84, "R4");
        rd_stb = 1; step("R4");
        // R4: armed clear
        wr_stb = 1; wdata = 8'h01; step("R4");
        check(rdata, 8'h01, "R4");
        xfer = 1; step("R6");
        check(rdata, 8'h81, "R6");
        frame_end = 1; step("R7");
        check(rdata, 8'h85, "R7");
        tdr_wr = 1; step("R5");
        check(rdata, 8'h01, "R5");
        // R6: set beats clear in same cycle
        tdr_wr = 1; xfer = 1; step("R6");
        check(rdata, 8'h81, "R6");
        tdr_wr = 1; step("R5");
        tx_dis = 1; step("R6");
        check(rdata, 8'h81, "R6");
        rx_done = 1; rx_mpb = 1; step("R9");
        check(rdata, 8'hC3, "R9");
        // R3: writing ones sets nothing, read-only bits untouched
        wr_stb = 1; wdata = 8'hFF; step("R3");
        check(rdata, 8'hC3, "R3");
        wr_stb = 1; wdata = 8'hBE; step("R4");
        check(rdata, 8'hC2, "R4");
        rd_stb = 1; step("R4");
        wr_stb = 1; wdata = 8'hBF; step("R4");
        check(rdata, 8'h83, "R4");
        ovr_err = 1; frm_err = 1; par_err = 1; step("R8");
        check(rdata, 8'hBB, "R8");
        rd_stb = 1; step("R8");
        // R8: parity set wins over same-cycle clear
        wr_stb = 1; wdata = 8'h00; par_err = 1; step("R8");
        check(rdata, 8'h0A, "R8");
        // R2: low-power entry overrides a same-cycle event
        lp_enter = 1; ovr_err = 1; step("R2");
        check(rdata, 8'h84, "R2");

        for (int k = 0; k < N_RAND; k++) begin
            rd_stb    = ($urandom % 4)  == 0;
            wr_stb    = ($urandom % 5)  == 0;
            wdata     = 8'($urandom);
            tdr_wr    = ($urandom % 8)  == 0;
            xfer      = ($urandom % 8)  == 0;
            tx_dis    = ($urandom % 32) == 0;
            frame_end = ($urandom % 6)  == 0;
            rx_done   = ($urandom % 8)  == 0;
            rx_mpb    = 1'($urandom);
            ovr_err   = ($urandom % 12) == 0;
            frm_err   = ($urandom % 12) == 0;
            par_err   = ($urandom % 12) == 0;
            lp_enter  = ($urandom % 64) == 0;
            step(lp_enter ? "R2" : "R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule